// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block holds and advances the coherence state of every line in a private write-back cache that sits on a shared snooping bus. Each line is in one of four states: invalid, shared, exclusive-clean or modified. Per cycle the block accepts at most one local processor operation (read, write or eviction) and at most one snooped bus transaction (read, read-exclusive or upgrade). Each carries a line index; tag lookup is done elsewhere.

For the local side it returns the bus request to issue and the line's next state. On a read miss it uses the sampled shared indication from the other caches to pick between exclusive-clean and shared. For the snoop side it returns the snooped line's next state and the block's own responses: the shared line, the dirty line, a flush of dirty data and an invalidation. Every bus and state transaction is atomic, so there are no transient states. New states are committed at the clock edge.

If a snoop and a local operation address the same line in the same cycle, the snoop is applied first. The local operation is then judged against the state the snoop left.

Top module: `mesi_line_ctrl`

## Requirements
- R1: Reset, active low and asynchronous, puts every line in invalid. State codes are invalid=2'b00, shared=2'b01, exclusive-clean=2'b10, modified=2'b11.
- R2: A local read (loc_op_i=1) to an invalid line issues a bus read (bus_req_o=1). The line fills to exclusive-clean when shared_in_i is low and to shared when it is high.
- R3: A local write (loc_op_i=2) to an invalid line issues a read-exclusive (bus_req_o=2), and the line becomes modified.
- R4: A local write to a shared line issues a dataless upgrade (bus_req_o=3), and the line becomes modified.
- R5: A local write to an exclusive-clean line becomes modified with no bus request. A local read to any valid line issues no bus request and leaves the state unchanged, whatever shared_in_i is.
- R6: A snooped read (snp_op_i=1) demotes modified or exclusive-clean to shared and leaves shared unchanged. snp_shared_o is high for any valid line, and snp_dirty_o and snp_flush_o are high only for a modified line.
- R7: A snooped read-exclusive (snp_op_i=2) or upgrade (snp_op_i=3) moves a valid line to invalid with snp_inval_o high and snp_shared_o high. A modified line also raises snp_dirty_o and snp_flush_o.
- R8: An eviction (loc_op_i=3) moves the line to invalid. A modified line issues a write-back (bus_req_o=4), and clean or invalid lines issue nothing.
- R9: When the snoop and the local operation address the same line in one cycle, the snoop's transition is applied first. The local operation's bus request and next state come from the post-snoop state, and that next state is committed.
- R10: A snoop to an invalid line, or no snoop (snp_op_i=0), gives no response and no state change. Operations on one line never change another line.
- R11: loc_state_o and snp_state_o show the indexed line's next state; with no operation they show its current state. A committed state holds until the next operation on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| loc_op_i | input | 2 | Local operation: 0 none, 1 read, 2 write, 3 evict |
| loc_idx_i | input | IDX_W | Line index of the local operation |
| shared_in_i | input | 1 | Sampled shared indication for this cache's own bus read |
| snp_op_i | input | 2 | Snooped transaction: 0 none, 1 read, 2 read-exclusive, 3 upgrade |
| snp_idx_i | input | IDX_W | Line index of the snooped transaction |
| bus_req_o | output | 3 | Bus request: 0 none, 1 read, 2 read-exclusive, 3 upgrade, 4 write-back |
| loc_state_o | output | 2 | Next state of the local line |
| snp_state_o | output | 2 | Next state of the snooped line after the snoop alone |
| snp_shared_o | output | 1 | Shared response: a valid copy is held |
| snp_dirty_o | output | 1 | Dirty response: the copy is modified |
| snp_flush_o | output | 1 | Supply dirty data onto the bus |
| snp_inval_o | output | 1 | The snooped valid line is being invalidated |

## Verification
The transition logic is driven with local reads, writes and evictions from every state, and with snooped reads, read-exclusives and upgrades against every state. The read miss is run with shared_in_i both low and high, so the two fill states can be told apart. Read hits are also run with shared_in_i high, which shows that the input is ignored on a hit. Same-line collisions of a snoop with a local read or write show whether the snoop really comes first: each wrong ordering gives a different bus request. Collisions on different lines, and a reset in the middle of the run, separate the per-line state from shared logic.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_state_e;

  typedef enum logic [1:0] {
    LOC_NONE  = 2'd0,
    LOC_RD    = 2'd1,
    LOC_WR    = 2'd2,
    LOC_EVICT = 2'd3
  } loc_op_e;

  typedef enum logic [1:0] {
    SNP_NONE = 2'd0,
    SNP_RD   = 2'd1,
    SNP_RDX  = 2'd2,
    SNP_UPG  = 2'd3
  } snp_op_e;

  typedef enum logic [2:0] {
    BUS_NONE = 3'd0,
    BUS_RD   = 3'd1,
    BUS_RDX  = 3'd2,
    BUS_UPG  = 3'd3,
    BUS_WB   = 3'd4
  } bus_req_e;

  typedef struct packed {
    logic shared;
    logic dirty;
    logic flush;
    logic inval;
  } snp_resp_t;

  function automatic logic st_valid(line_state_e s);
    return s != ST_I;
  endfunction
endpackage

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
(
  input  line_state_e cur_i,
  input  snp_op_e     op_i,
  output line_state_e nxt_o,
  output snp_resp_t   resp_o
);
  always_comb begin
    nxt_o  = cur_i;
    resp_o = '0;
    if (op_i != SNP_NONE && st_valid(cur_i)) begin
      resp_o.shared = 1'b1;
      resp_o.dirty  = (cur_i == ST_M);
      resp_o.flush  = (cur_i == ST_M);
      unique case (op_i)
        SNP_RD:           nxt_o = ST_S;
        SNP_RDX, SNP_UPG: begin
          nxt_o        = ST_I;
          resp_o.inval = 1'b1;
        end
        default:          nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
  import mesi_pkg::*;
(
  input  line_state_e cur_i,
  input  loc_op_e     op_i,
  input  logic        shared_in_i,
  output line_state_e nxt_o,
  output bus_req_e    req_o
);
  always_comb begin
    nxt_o = cur_i;
    req_o = BUS_NONE;
    unique case (op_i)
      LOC_RD: begin
        if (cur_i == ST_I) begin
          req_o = BUS_RD;
          nxt_o = shared_in_i ? ST_S : ST_E;
        end
      end
      LOC_WR: begin
        nxt_o = ST_M;
        unique case (cur_i)
          ST_I:    req_o = BUS_RDX;
          ST_S:    req_o = BUS_UPG;
          default: req_o = BUS_NONE; // E->M silent, M stays
        endcase
      end
      LOC_EVICT: begin
        nxt_o = ST_I;
        if (cur_i == ST_M) req_o = BUS_WB;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              snp_we_i,
  input  logic [IDX_W-1:0]  snp_widx_i,
  input  line_state_e       snp_wdata_i,
  input  logic              loc_we_i,
  input  logic [IDX_W-1:0]  loc_widx_i,
  input  line_state_e       loc_wdata_i,
  input  logic [IDX_W-1:0]  rd_a_idx_i,
  output line_state_e       rd_a_o,
  input  logic [IDX_W-1:0]  rd_b_idx_i,
  output line_state_e       rd_b_o
);
  line_state_e st_q [NUM_LINES];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    // local write is applied after the snoop, so it wins on a collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g] <= ST_I;
      end else if (loc_we_i && loc_widx_i == IDX_W'(g)) begin
        st_q[g] <= loc_wdata_i;
      end else if (snp_we_i && snp_widx_i == IDX_W'(g)) begin
        st_q[g] <= snp_wdata_i;
      end
    end
  end

  always_comb begin
    rd_a_o = ST_I;
    rd_b_o = ST_I;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rd_a_idx_i == IDX_W'(i)) rd_a_o = st_q[i];
      if (rd_b_idx_i == IDX_W'(i)) rd_b_o = st_q[i];
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       loc_op_i,
  input  logic [IDX_W-1:0] loc_idx_i,
  input  logic             shared_in_i,
  input  logic [1:0]       snp_op_i,
  input  logic [IDX_W-1:0] snp_idx_i,
  output logic [2:0]       bus_req_o,
  output logic [1:0]       loc_state_o,
  output logic [1:0]       snp_state_o,
  output logic             snp_shared_o,
  output logic             snp_dirty_o,
  output logic             snp_flush_o,
  output logic             snp_inval_o
);
  loc_op_e     loc_op;
  snp_op_e     snp_op;
  line_state_e snp_cur, snp_nxt, loc_arr, loc_cur, loc_nxt;
  snp_resp_t   snp_resp;
  bus_req_e    loc_req;
  logic        collide;

  assign loc_op = loc_op_e'(loc_op_i);
  assign snp_op = snp_op_e'(snp_op_i);

  mesi_state_array #(.NUM_LINES(NUM_LINES)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .snp_we_i    (snp_op != SNP_NONE),
    .snp_widx_i  (snp_idx_i),
    .snp_wdata_i (snp_nxt),
    .loc_we_i    (loc_op != LOC_NONE),
    .loc_widx_i  (loc_idx_i),
    .loc_wdata_i (loc_nxt),
    .rd_a_idx_i  (snp_idx_i),
    .rd_a_o      (snp_cur),
    .rd_b_idx_i  (loc_idx_i),
    .rd_b_o      (loc_arr)
  );

  mesi_snoop_unit u_snoop (
    .cur_i  (snp_cur),
    .op_i   (snp_op),
    .nxt_o  (snp_nxt),
    .resp_o (snp_resp)
  );

  // snoop first: local op sees the post-snoop state of a shared index
  assign collide = (snp_op != SNP_NONE) && (snp_idx_i == loc_idx_i);
  assign loc_cur = collide ? snp_nxt : loc_arr;

  mesi_local_unit u_local (
    .cur_i       (loc_cur),
    .op_i        (loc_op),
    .shared_in_i (shared_in_i),
    .nxt_o       (loc_nxt),
    .req_o       (loc_req)
  );

  assign bus_req_o    = loc_req;
  assign loc_state_o  = loc_nxt;
  assign snp_state_o  = snp_nxt;
  assign snp_shared_o = snp_resp.shared;
  assign snp_dirty_o  = snp_resp.dirty;
  assign snp_flush_o  = snp_resp.flush;
  assign snp_inval_o  = snp_resp.inval;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       loc_op_i,
  input logic [IDX_W-1:0] loc_idx_i,
  input logic             shared_in_i,
  input logic [1:0]       snp_op_i,
  input logic [2:0]       bus_req_o,
  input logic [1:0]       loc_state_o,
  input logic [1:0]       snp_state_o,
  input logic             snp_shared_o,
  input logic             snp_dirty_o,
  input logic             snp_flush_o,
  input logic             snp_inval_o
);
  a_r2_fill_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == 3'd1 |-> loc_state_o == (shared_in_i ? 2'b01 : 2'b10));

  a_r3_rdx_to_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == 3'd2 |-> loc_state_o == 2'b11 && loc_op_i == 2'd2);

  a_r4_upg_to_mod: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == 3'd3 |-> loc_state_o == 2'b11 && loc_op_i == 2'd2);

  a_r8_wb_to_inv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == 3'd4 |-> loc_state_o == 2'b00 && loc_op_i == 2'd3);

  a_r6_dirty_is_shared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_dirty_o |-> snp_shared_o && snp_flush_o);

  a_r6_rd_demotes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snp_op_i == 2'd1 && snp_shared_o) |-> snp_state_o == 2'b01 && !snp_inval_o);

  a_r7_inval_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_inval_o |-> snp_shared_o && snp_state_o == 2'b00);

  a_r10_idle_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_op_i == 2'd0 |-> !snp_shared_o && !snp_dirty_o && !snp_flush_o && !snp_inval_o);

  a_r11_state_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_op_i != 2'd0 |=>
      (!(loc_op_i == 2'd0 && snp_op_i == 2'd0 && loc_idx_i == $past(loc_idx_i))
       || loc_state_o == $past(loc_state_o)));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDX_W(IDX_W)) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .loc_op_i     (loc_op_i),
  .loc_idx_i    (loc_idx_i),
  .shared_in_i  (shared_in_i),
  .snp_op_i     (snp_op_i),
  .bus_req_o    (bus_req_o),
  .loc_state_o  (loc_state_o),
  .snp_state_o  (snp_state_o),
  .snp_shared_o (snp_shared_o),
  .snp_dirty_o  (snp_dirty_o),
  .snp_flush_o  (snp_flush_o),
  .snp_inval_o  (snp_inval_o)
);

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;
  localparam int NUM_LINES = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] loc_op = '0, snp_op = '0;
  logic [IDX_W-1:0] loc_idx = '0, snp_idx = '0;
  logic shared_in = 1'b0;
  logic [2:0] bus_req;
  logic [1:0] loc_state, snp_state;
  logic snp_shared, snp_dirty, snp_flush, snp_inval;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NUM_LINES(NUM_LINES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .loc_op_i(loc_op), .loc_idx_i(loc_idx), .shared_in_i(shared_in),
    .snp_op_i(snp_op), .snp_idx_i(snp_idx),
    .bus_req_o(bus_req), .loc_state_o(loc_state), .snp_state_o(snp_state),
    .snp_shared_o(snp_shared), .snp_dirty_o(snp_dirty),
    .snp_flush_o(snp_flush), .snp_inval_o(snp_inval)
  );

  // {req[25:22], lop[21:20], lidx[19:17], sop[16:15], sidx[14:12], sh[11],
  //  bus[10:8], lst[7:6], sst[5:4], resp{shared,dirty,flush,inval}[3:0]}
  localparam int NV = 21;
  localparam logic [25:0] VEC [NV] = '{
    {4'd2,  2'd1, 3'd0, 2'd0, 3'd7, 1'b0, 3'd1, 2'd2, 2'd0, 4'b0000}, // R2 miss -> E
    {4'd2,  2'd1, 3'd1, 2'd0, 3'd7, 1'b1, 3'd1, 2'd1, 2'd0, 4'b0000}, // R2 miss -> S
    {4'd5,  2'd1, 3'd0, 2'd0, 3'd7, 1'b1, 3'd0, 2'd2, 2'd0, 4'b0000}, // R5 hit, shared ignored
    {4'd5,  2'd2, 3'd0, 2'd0, 3'd7, 1'b0, 3'd0, 2'd3, 2'd0, 4'b0000}, // R5 E->M silent
    {4'd4,  2'd2, 3'd1, 2'd0, 3'd7, 1'b0, 3'd3, 2'd3, 2'd0, 4'b0000}, // R4 upgrade
    {4'd3,  2'd2, 3'd2, 2'd0, 3'd7, 1'b0, 3'd2, 2'd3, 2'd0, 4'b0000}, // R3 rdx
    {4'd6,  2'd0, 3'd0, 2'd1, 3'd0, 1'b0, 3'd0, 2'd1, 2'd1, 4'b1110}, // R6 M->S flush
    {4'd2,  2'd1, 3'd3, 2'd0, 3'd7, 1'b0, 3'd1, 2'd2, 2'd0, 4'b0000}, // R2
    {4'd6,  2'd0, 3'd3, 2'd1, 3'd3, 1'b0, 3'd0, 2'd1, 2'd1, 4'b1000}, // R6 E->S
    {4'd6,  2'd0, 3'd3, 2'd1, 3'd3, 1'b0, 3'd0, 2'd1, 2'd1, 4'b1000}, // R6 S stays
    {4'd7,  2'd0, 3'd1, 2'd2, 3'd1, 1'b0, 3'd0, 2'd0, 2'd0, 4'b1111}, // R7 rdx on M
    {4'd7,  2'd0, 3'd3, 2'd3, 3'd3, 1'b0, 3'd0, 2'd0, 2'd0, 4'b1001}, // R7 upg on S
    {4'd10, 2'd0, 3'd1, 2'd1, 3'd1, 1'b0, 3'd0, 2'd0, 2'd0, 4'b0000}, // R10 snoop on I
    {4'd8,  2'd3, 3'd2, 2'd0, 3'd7, 1'b0, 3'd4, 2'd0, 2'd0, 4'b0000}, // R8 evict M
    {4'd8,  2'd3, 3'd0, 2'd0, 3'd7, 1'b0, 3'd0, 2'd0, 2'd0, 4'b0000}, // R8 evict S
    {4'd3,  2'd2, 3'd4, 2'd0, 3'd7, 1'b0, 3'd2, 2'd3, 2'd0, 4'b0000}, // R3
    {4'd9,  2'd1, 3'd4, 2'd2, 3'd4, 1'b1, 3'd1, 2'd1, 2'd0, 4'b1111}, // R9 rdx then read
    {4'd9,  2'd2, 3'd4, 2'd3, 3'd4, 1'b0, 3'd2, 2'd3, 2'd0, 4'b1001}, // R9 upg then write
    {4'd10, 2'd2, 3'd5, 2'd1, 3'd4, 1'b0, 3'd2, 2'd3, 2'd1, 4'b1110}, // R10 separate lines
    {4'd11, 2'd0, 3'd4, 2'd0, 3'd5, 1'b0, 3'd0, 2'd1, 2'd3, 4'b0000}, // R11 committed view
    {4'd8,  2'd3, 3'd6, 2'd0, 3'd7, 1'b0, 3'd0, 2'd0, 2'd0, 4'b0000}  // R8 evict I
  };

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    loc_op = '0; snp_op = '0; shared_in = 1'b0;
  endtask

  initial begin : watchdog
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1: reset state of every line
    for (int i = 0; i < NUM_LINES; i++) begin
      loc_idx = IDX_W'(i); #1;
      check("R1", "reset loc_state", int'(loc_state), 0);
    end
    @(negedge clk) rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      loc_op = VEC[v][21:20]; loc_idx = VEC[v][19:17];
      snp_op = VEC[v][16:15]; snp_idx = VEC[v][14:12];
      shared_in = VEC[v][11];
      #1;
      begin
        string tag;
        tag = $sformatf("R%0d v%0d", VEC[v][25:22], v);
        check(tag, "bus_req",   int'(bus_req),   int'(VEC[v][10:8]));
        check(tag, "loc_state", int'(loc_state), int'(VEC[v][7:6]));
        check(tag, "snp_state", int'(snp_state), int'(VEC[v][5:4]));
        check(tag, "snp_resp",
              int'({snp_shared, snp_dirty, snp_flush, snp_inval}), int'(VEC[v][3:0]));
      end
    end

    // R11: line 5 still modified after idle cycles
    @(negedge clk) idle();
    repeat (2) @(negedge clk);
    loc_idx = 3'd5; #1;
    check("R11", "held state line5", int'(loc_state), 3);

    // R1: mid-run asynchronous reset clears lines
    #0.5 rst_ni = 1'b0; #0.5;
    check("R1", "async reset line5", int'(loc_state), 0);
    @(negedge clk) rst_ni = 1'b1;
    snp_idx = 3'd4; #1;
    check("R1", "post reset line4", int'(snp_state), 0);

    // R5: write to modified stays modified, no bus request
    @(negedge clk) loc_op = 2'd2; loc_idx = 3'd7; #1;
    check("R3", "rdx line7", int'(bus_req), 2);
    @(negedge clk) loc_op = 2'd2; #1;
    check("R5", "write hit M bus", int'(bus_req), 0);
    check("R5", "write hit M state", int'(loc_state), 3);
    @(negedge clk) idle();
    #1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule